// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus side of a byte-wide serial memory of up to 32K locations. It oversamples the two-wire clock and data lines with the system clock and removes short glitches from both. It finds start and stop conditions and recognises its own device word. It takes a two-byte memory address and accepts write bytes, or it returns read bytes MSB first on an open-drain data output. Acknowledge is handled in both directions: the block acknowledges what it receives, and it samples the master's acknowledge after each byte it sends.

On the memory side the block has a simple port. It issues one write request per received data byte. It issues one read request whose data must be valid on the following system clock and held until the next request. A commit pulse tells an external write engine to start the internal programming cycle, and that engine reports back through a busy input. While busy is high every device word is left unacknowledged, so a master can poll for the end of the cycle. An internal address counter supports current-address, random and sequential reads. It wraps inside a 64-byte page after writes and over the whole array after reads.

Top module: `twi_mem_slave`

## Requirements
- R1: A high-to-low change of the filtered data line while the filtered clock is high is a start, and it restarts reception of a device word from any state. A low-to-high change while the clock is high is a stop, and it returns the block to idle.
- R2: A device word made of the code 1010 in bits 7..4, then bits 3..1 equal to `dev_sel` (A2 in bit 3), then R/W in bit 0 (0 write, 1 read), is acknowledged by holding the data line low through the ninth clock.
- R3: A device word whose code or select bits differ gets no acknowledge. No memory request follows it before the next start.
- R4: A write carries a high address byte, of which bits 6..0 become address bits 14..8 and bit 7 is ignored, then a low address byte. Each following data byte produces exactly one `mem_we` carrying the current address and the byte, and the byte is acknowledged.
- R5: Within one write the address advances only in its low 6 bits, so that after offset 63 of a page the next byte goes to offset 0 of the same page.
- R6: A stop that follows at least one written data byte gives a single-cycle `mem_commit`. A stop after a transfer with no data byte, such as a dummy write or a poll, gives none.
- R7: While `wr_busy` is high every device word is left unacknowledged and no write request is issued. Once `wr_busy` is low a matching device word is acknowledged again.
- R8: A read with no preceding address returns the byte at the counter, which holds the last accessed address plus one. A dummy write that loads an address, followed by a repeated start with R/W = 1, reads from the loaded address.
- R9: During reads the address advances over the whole array, from 0x7FFF to 0x0000 and across page boundaries. A master acknowledge of 0 makes the next byte follow.
- R10: A master acknowledge of 1 after a read byte ends the read. The data line stays released until the next start.
- R11: `sda_oe` changes only while the clock line is low. Read data goes out MSB first, with `sda_oe` = 1 for a 0 bit.
- R12: A change on either line that lasts fewer than `GLITCH_CYC` system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| dev_sel | input | 3 | Hard-wired device select bits (A2..A0) |
| wr_busy | input | 1 | Write engine is in its programming cycle |
| mem_addr | output | 15 | Memory address for read and write requests |
| mem_wdata | output | 8 | Write data byte |
| mem_we | output | 1 | One-cycle write request |
| mem_re | output | 1 | One-cycle read request, data due next clock |
| mem_rdata | input | 8 | Read data, held until the next request |
| mem_commit | output | 1 | One-cycle request to start the programming cycle |

## Verification
A wrong protocol state shows at the ports within one bus bit. It appears either as a missing or extra acknowledge low on the ninth clock, or as `sda_oe` moving while the clock is high. A corrupted address counter shows one byte later, as a write request at the wrong address or a wrong byte read back. The wrap tests separate page-wrapped writes from array-wrapped reads. A lost write flag shows at the next stop, as a missing or spurious commit pulse. A filter that is too weak turns a short data pulse inside a byte into a false stop, which is seen as a missing acknowledge and a missing write request.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_ACK,
    S_TX,
    S_RACK
  } state_t;
endpackage

// File: rtl/twi_deglitch.sv
module twi_deglitch #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(GLITCH_CYC) + 1;

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;

  always_comb begin
    cnt_d = '0;
    out_d = out_q;
    if (sync_q[1] != out_q) begin
      if (cnt_q == CW'(GLITCH_CYC - 1)) out_d = sync_q[1];
      else                               cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      cnt_q  <= cnt_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc_rd,
  input  logic              inc_wr,
  input  logic [7:0]        din,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] a_q, a_d;
  logic              en;

  assign en = ld_hi | ld_lo | inc_rd | inc_wr;

  always_comb begin
    a_d = a_q;
    if (ld_hi)       a_d[ADDR_W-1:8] = din[HI_W-1:0];
    else if (ld_lo)  a_d[7:0] = din;
    else if (inc_rd) a_d = a_q + ADDR_W'(1);
    else if (inc_wr) a_d[PAGE_W-1:0] = a_q[PAGE_W-1:0] + PAGE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  a_q <= '0;
    else if (en) a_q <= a_d;
  end

  assign addr = a_q;
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_W     = 6,
  parameter int GLITCH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic              wr_busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              mem_commit
);
  logic [1:0] rst_sq;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_i = rst_sq[1];

  logic scl_f, sda_f, scl_p, sda_p;

  twi_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_scl_flt (
    .clk(clk), .rst_n(rst_i), .din(scl_in), .dout(scl_f));
  twi_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_sda_flt (
    .clk(clk), .rst_n(rst_i), .din(sda_in), .dout(sda_f));

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

  state_t     st_q, st_d, nx_q, nx_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       oe_q, oe_d, dirty_q, dirty_d;
  logic       ld_hi, ld_lo, inc_rd, inc_wr;
  logic       dev_hit;

  assign dev_hit = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == dev_sel) && !wr_busy;

  always_comb begin
    st_d = st_q;  nx_d = nx_q;  bit_d = bit_q;  sh_d = sh_q;
    oe_d = oe_q;  dirty_d = dirty_q;
    ld_hi = 1'b0; ld_lo = 1'b0; inc_rd = 1'b0; inc_wr = 1'b0;
    mem_we = 1'b0; mem_re = 1'b0; mem_commit = 1'b0;
    if (stop_ev) begin
      st_d       = S_IDLE;
      oe_d       = 1'b0;
      mem_commit = dirty_q;
      dirty_d    = 1'b0;
    end else if (start_ev) begin
      st_d  = S_DEV;
      bit_d = 4'd0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        S_DEV, S_AHI, S_ALO, S_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_f};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d = 4'd0;
            oe_d  = 1'b1;
            st_d  = S_ACK;
            case (st_q)
              S_DEV: begin
                if (!dev_hit) begin
                  oe_d = 1'b0;
                  st_d = S_IDLE;
                end else if (sh_q[0]) begin
                  nx_d   = S_TX;
                  mem_re = 1'b1;
                end else begin
                  nx_d = S_AHI;
                end
              end
              S_AHI: begin
                ld_hi = 1'b1;
                nx_d  = S_ALO;
              end
              S_ALO: begin
                ld_lo = 1'b1;
                nx_d  = S_WDAT;
              end
              default: begin
                mem_we  = 1'b1;
                inc_wr  = 1'b1;
                dirty_d = 1'b1;
                nx_d    = S_WDAT;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            st_d = nx_q;
            if (nx_q == S_TX) begin
              sh_d  = mem_rdata;
              oe_d  = ~mem_rdata[7];
              bit_d = 4'd1;
            end else begin
              oe_d  = 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d   = 1'b0;
              st_d   = S_RACK;
              inc_rd = 1'b1;
            end else begin
              oe_d  = ~sh_q[6];
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            if (!sda_f) begin
              st_d   = S_ACK;
              nx_d   = S_TX;
              mem_re = 1'b1;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= S_IDLE;
      nx_q    <= S_IDLE;
      bit_q   <= 4'd0;
      sh_q    <= 8'h00;
      oe_q    <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      nx_q    <= nx_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      dirty_q <= dirty_d;
    end
  end

  twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_i), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .inc_rd(inc_rd), .inc_wr(inc_wr), .din(sh_q), .addr(mem_addr));

  assign sda_oe    = oe_q;
  assign mem_wdata = sh_q;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_oe,
  input logic wr_busy,
  input logic mem_we,
  input logic mem_commit
);
  // R11
  oe_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in);

  // R7
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !mem_we);

  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_commit |=> !mem_commit);

  // R4
  write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_oe);
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .wr_busy(wr_busy), .mem_we(mem_we), .mem_commit(mem_commit));

// File: tb/twi_mem_slave_test.sv
`timescale 1ns/1ps
module twi_mem_slave_test;
  localparam int Q = 20, H = 40, GL = 4, BUSY_CYC = 3000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, m_scl, m_sda;
  logic        scl_in, sda_in, sda_oe, wr_busy, mem_we, mem_re, mem_commit;
  logic [2:0]  dev_sel;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  assign scl_in  = m_scl;
  assign sda_in  = m_sda & ~sda_oe;
  assign dev_sel = 3'b101;

  twi_mem_slave #(.ADDR_W(15), .PAGE_W(6), .GLITCH_CYC(GL)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .wr_busy(wr_busy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_commit(mem_commit));

  function automatic logic [7:0] pat(input logic [8:0] a);
    return a[7:0] ^ 8'h6C ^ {7'd0, a[8]};
  endfunction

  // memory and write engine model
  logic [7:0]  bm [512];
  logic        wv [512];
  int          busy_cnt, we_cnt, commit_cnt;
  logic [14:0] last_wa;
  logic [7:0]  last_wd;

  assign wr_busy = (busy_cnt != 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) wv[i] <= 1'b0;
      busy_cnt <= 0; we_cnt <= 0; commit_cnt <= 0;
      last_wa <= '0; last_wd <= '0; mem_rdata <= '0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (mem_commit) begin
        busy_cnt   <= BUSY_CYC;
        commit_cnt <= commit_cnt + 1;
      end
      if (mem_we) begin
        bm[mem_addr[8:0]] <= mem_wdata;
        wv[mem_addr[8:0]] <= 1'b1;
        last_wa <= mem_addr;
        last_wd <= mem_wdata;
        we_cnt  <= we_cnt + 1;
      end
      if (mem_re) mem_rdata <= wv[mem_addr[8:0]] ? bm[mem_addr[8:0]] : pat(mem_addr[8:0]);
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    wc(Q); m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(H); m_sda = 1'b0; wc(H); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wc(Q); m_sda = 1'b0; wc(Q); m_scl = 1'b1; wc(H); m_sda = 1'b1; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      wc(Q); m_sda = b[i]; wc(Q); m_scl = 1'b1;
      if (glitch && i == 3) begin
        wc(10); m_sda = 1'b1; wc(GL - 1); m_sda = b[i]; wc(H - 10 - (GL - 1));
      end else begin
        wc(H);
      end
      m_scl = 1'b0;
    end
    wc(Q); m_sda = 1'b1; wc(Q); m_scl = 1'b1; wc(H / 2);
    acked = ~sda_in;
    wc(H / 2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wc(2 * Q); m_scl = 1'b1; wc(H / 2);
      b = {b[6:0], sda_in};
      wc(H / 2); m_scl = 1'b0;
    end
    wc(Q); m_sda = mack; wc(Q); m_scl = 1'b1; wc(H); m_scl = 1'b0;
  endtask

  task automatic snd(input logic [7:0] b, input string tag, input int exp_ack);
    bit a;
    send_byte(b, 1'b0, a);
    chk(tag, int'(a), exp_ack);
  endtask

  task automatic wait_idle();
    while (wr_busy) @(negedge clk);
    wc(5);
  endtask

  // bit 8: acknowledge expected; bits 7..0: device word
  localparam logic [8:0] DEVTAB [7] = '{9'h1AA, 9'h0A8, 9'h0AE, 9'h0BA,
                                         9'h02A, 9'h0EA, 9'h0A2};

  initial begin
    int guard = 0;
    while (guard < 190000) begin @(posedge clk); guard++; end
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", guard, 0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit a;
    int c0;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    wc(10);
    chk("R11 reset sda_oe", int'(sda_oe), 0);
    chk("R6 reset commit", int'(mem_commit), 0);
    chk("R4 reset we", int'(mem_we), 0);
    rst_n = 1'b1;
    wc(20);

    // R2 R3 device word table
    for (int i = 0; i < 7; i++) begin
      bus_start();
      send_byte(DEVTAB[i][7:0], 1'b0, a);
      chk($sformatf("R2/R3 dev word %0h", DEVTAB[i][7:0]), int'(a), int'(DEVTAB[i][8]));
      bus_stop();
    end
    chk("R3 no write after mismatch", we_cnt, 0);
    chk("R6 no commit without data", commit_cnt, 0);

    // R4 byte write, top address bit ignored
    bus_start();
    snd(8'hAA, "R2 dev ack", 1);
    snd(8'h81, "R4 addr hi ack", 1);
    snd(8'h23, "R4 addr lo ack", 1);
    snd(8'h5C, "R4 data ack", 1);
    chk("R4 write addr", int'(last_wa), 'h0123);
    chk("R4 write data", int'(last_wd), 'h5C);
    chk("R4 one write", we_cnt, 1);
    bus_stop();
    wc(5);
    chk("R6 R1 commit on stop", commit_cnt, 1);

    // R7 acknowledge polling
    bus_start();
    snd(8'hAA, "R7 poll nack while busy", 0);
    bus_stop();
    bus_start();
    snd(8'hAB, "R7 read nack while busy", 0);
    bus_stop();
    wait_idle();
    bus_start();
    snd(8'hAA, "R7 ack after busy", 1);
    bus_stop();
    wc(5);
    chk("R6 no commit after poll", commit_cnt, 1);

    // R5 page write wrap
    bus_start();
    snd(8'hAA, "R5 dev ack", 1);
    snd(8'h01, "R5 hi ack", 1);
    snd(8'h3E, "R5 lo ack", 1);
    snd(8'h11, "R5 d0 ack", 1);  chk("R5 addr 0", int'(last_wa), 'h013E);
    snd(8'h22, "R5 d1 ack", 1);  chk("R5 addr 1", int'(last_wa), 'h013F);
    snd(8'h33, "R5 d2 ack", 1);  chk("R5 addr wrap", int'(last_wa), 'h0100);
    snd(8'h44, "R5 d3 ack", 1);  chk("R5 addr 3", int'(last_wa), 'h0101);
    bus_stop();
    wait_idle();

    // R8 current address read after page write
    bus_start();
    snd(8'hAB, "R8 dev ack", 1);
    recv_byte(1'b1, d);
    chk("R8 current read data", int'(d), int'(pat(9'h102)));
    bus_stop();

    // R8 R1 random read with repeated start, sequential
    bus_start();
    snd(8'hAA, "R8 dummy dev", 1);
    snd(8'h01, "R8 dummy hi", 1);
    snd(8'h3E, "R8 dummy lo", 1);
    bus_start();
    snd(8'hAB, "R1 repeated start read", 1);
    recv_byte(1'b0, d); chk("R8 random data", int'(d), 'h11);
    recv_byte(1'b1, d); chk("R11 seq data MSB first", int'(d), 'h22);
    bus_stop();
    bus_start();
    snd(8'hAB, "R9 dev ack", 1);
    recv_byte(1'b1, d);
    chk("R9 read crosses page", int'(d), int'(pat(9'h140)));
    bus_stop();

    // R9 array wrap, R10 nack release
    bus_start();
    snd(8'hAA, "R9 dummy dev", 1);
    snd(8'h7F, "R9 dummy hi", 1);
    snd(8'hFE, "R9 dummy lo", 1);
    bus_start();
    snd(8'hAB, "R9 read dev", 1);
    recv_byte(1'b0, d); chk("R9 7FFE", int'(d), int'(pat(9'h1FE)));
    recv_byte(1'b0, d); chk("R9 7FFF", int'(d), int'(pat(9'h1FF)));
    recv_byte(1'b1, d); chk("R9 wrap to 0", int'(d), int'(pat(9'h000)));
    wc(12);
    chk("R10 released after nack", int'(sda_oe), 0);
    wc(2 * Q);
    chk("R10 still released", int'(sda_oe), 0);
    bus_stop();

    // R12 short pulse on SDA inside a data byte
    c0 = we_cnt;
    bus_start();
    snd(8'hAA, "R12 dev ack", 1);
    snd(8'h00, "R12 hi ack", 1);
    snd(8'h50, "R12 lo ack", 1);
    send_byte(8'h00, 1'b1, a);
    chk("R12 glitch byte acked", int'(a), 1);
    chk("R12 write count", we_cnt, c0 + 1);
    chk("R12 write addr", int'(last_wa), 'h0050);
    chk("R12 write data", int'(last_wd), 'h00);
    bus_stop();
    wc(5);
    chk("R6 commit after glitch write", commit_cnt, 3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule